// File: doc/BRIEF.md
# Host-to-Coprocessor Doorbell Mailbox

This block carries messages between a host processor and a security coprocessor. Each direction has a sixteen-word (64-byte) payload store and its own single-slot handshake. On the host side there is a plain 32-bit register port with combinational read data. The host fills the input payload and then writes the doorbell register. The coprocessor sees a one-cycle doorbell pulse, reads the words through its own read port and returns a consume strobe. That strobe makes the input side ready again and raises an interrupt-status event.

The output direction works the same way in reverse. The coprocessor fills the output payload and pulses a post strobe. The host reads the words and writes the acknowledge register, which reopens the output slot. Both events land in one write-1-to-clear interrupt status register. A mask register with matching bit positions gates the status onto a single interrupt line. A doorbell or post that arrives while its slot is still busy is dropped, and a sticky overrun flag for that direction is set.

Host word-address map (6-bit address): 0x00 input doorbell (write, data ignored); 0x01 input status (bit 0 = input ready); 0x02 interrupt status (bit 0 = output-doorbell event, bit 1 = input-ready event, write 1 to clear); 0x03 interrupt mask (same bit positions, 1 = masked); 0x04 output acknowledge (write, data ignored; read bit 0 = output ready); 0x05 overrun flags (bit 0 = input, bit 1 = output, write 1 to clear); 0x10–0x1F input payload words 0–15; 0x20–0x2F output payload words 0–15 (read only).

Top module: `mbx_doorbell`

## Requirements
- R1: After reset, input ready reads 1, output ready (copOutReady and bit 0 of 0x04) is 1, interrupt status and overrun read 0, the mask reads 2'b11, hostIrq is 0 and copInDoorbell is 0.
- R2: While input ready is 1, a host write to 0x10+i stores word i. The word reads back at host address 0x10+i and on copInRdData when copInRdAddr is i.
- R3: A host write to 0x00 while input ready is 1 clears input ready and drives copInDoorbell high for exactly the one cycle after the write edge.
- R4: A copInConsume strobe while input ready is 0 sets input ready and sets bit 1 of the interrupt status. A consume while input ready is already 1 changes neither.
- R5: While input ready is 0, a doorbell write gives no copInDoorbell pulse and sets overrun bit 0, and an input payload write leaves the stored word unchanged.
- R6: A copOutPost while output ready is 1 clears output ready and sets bit 0 of the interrupt status. Words written by the coprocessor while output ready is 1 read back at host address 0x20+i.
- R7: A host write to 0x04 sets output ready. While output ready is 0 and no acknowledge is written, a post is dropped and sets overrun bit 1, and a coprocessor payload write is ignored.
- R8: When an acknowledge write and a post fall on the same edge, the acknowledge is applied first. The post is then accepted: output ready ends at 0, status bit 0 is set and no overrun is flagged.
- R9: Writing 1 to an interrupt status bit clears it. If the same bit's event occurs on that edge, the bit stays set.
- R10: hostIrq is high exactly when some interrupt status bit is 1 and its mask bit is 0.
- R11: Overrun flags are sticky until the host writes 1 to them at 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 6 | Host word address |
| hostWe | input | 1 | Host write strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data (combinational from hostAddr) |
| hostIrq | output | 1 | Host interrupt line |
| copInDoorbell | output | 1 | One-cycle pulse: new input command posted |
| copInConsume | input | 1 | Coprocessor has processed the input command |
| copInRdAddr | input | 4 | Coprocessor input payload read index |
| copInRdData | output | 32 | Input payload word at copInRdAddr |
| copOutWe | input | 1 | Coprocessor output payload write strobe |
| copOutWAddr | input | 4 | Output payload write index |
| copOutWData | input | 32 | Output payload write data |
| copOutPost | input | 1 | Coprocessor posts an output command |
| copOutReady | output | 1 | Output slot free (host processed previous post) |

## Verification
The input-ready, output-ready, status and overrun flags can be read from the host register port, and the output-ready flag also drives copOutReady. A wrong flag value therefore shows at the ports on the first host read after the faulty edge. A wrong doorbell pulse shows on copInDoorbell in the very next cycle. A wrong gating of payload writes is not visible at once: it appears only when the word is read back, which is why every dropped-write test reads the word it targeted. The irq line is combinational from status and mask, so a wrong mask decode shows in the same cycle as the mask write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W    = 32;
  localparam int PAY_WORDS = 16;
  localparam int IDX_W     = $clog2(PAY_WORDS);
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] REG_DOORBELL = 6'h00;
  localparam logic [ADDR_W-1:0] REG_INSTAT   = 6'h01;
  localparam logic [ADDR_W-1:0] REG_IRQSTAT  = 6'h02;
  localparam logic [ADDR_W-1:0] REG_IRQMASK  = 6'h03;
  localparam logic [ADDR_W-1:0] REG_OUTACK   = 6'h04;
  localparam logic [ADDR_W-1:0] REG_OVERRUN  = 6'h05;
  localparam logic [1:0]        WIN_IN       = 2'b01;
  localparam logic [1:0]        WIN_OUT      = 2'b10;

  typedef enum logic [1:0] {RD_REG, RD_IN, RD_OUT} rdSel_t;

  typedef struct packed {
    logic             inPayWe;
    logic             outPayWe;
    logic [IDX_W-1:0] hostIdx;
    rdSel_t           rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [1:0]        hostBits,
  input  logic              copInConsume,
  input  logic              copOutWe,
  input  logic              copOutPost,
  output logic              copInDoorbell,
  output logic              copOutReady,
  output logic              hostIrq,
  output logic [DATA_W-1:0] regRdata,
  output ctrlStrb_t         strb
);
  logic       inReady, outReady;
  logic [1:0] irqStat, irqMask, ovr;
  logic       dbPulse;

  logic wrDb, wrStat, wrMask, wrAck, wrOvr;
  logic effOutReady, postAccept, dbAccept, consumeAccept;
  logic [1:0] statSet, statClr, ovrSet, ovrClr;

  always_comb begin
    wrDb   = hostWe && (hostAddr == REG_DOORBELL);
    wrStat = hostWe && (hostAddr == REG_IRQSTAT);
    wrMask = hostWe && (hostAddr == REG_IRQMASK);
    wrAck  = hostWe && (hostAddr == REG_OUTACK);
    wrOvr  = hostWe && (hostAddr == REG_OVERRUN);

    dbAccept      = wrDb && inReady;
    consumeAccept = copInConsume && !inReady;
    // acknowledge is applied before a same-edge post
    effOutReady   = outReady || wrAck;
    postAccept    = copOutPost && effOutReady;

    statSet = {consumeAccept, postAccept};
    statClr = wrStat ? hostBits : 2'b00;
    ovrSet  = {copOutPost && !effOutReady, wrDb && !inReady};
    ovrClr  = wrOvr ? hostBits : 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReady  <= 1'b1;
      outReady <= 1'b1;
      irqStat  <= 2'b00;
      irqMask  <= 2'b11;
      ovr      <= 2'b00;
      dbPulse  <= 1'b0;
    end else begin
      if (dbAccept)           inReady <= 1'b0;
      else if (consumeAccept) inReady <= 1'b1;

      if (postAccept)  outReady <= 1'b0;
      else if (wrAck)  outReady <= 1'b1;

      irqStat <= (irqStat & ~statClr) | statSet;
      ovr     <= (ovr & ~ovrClr) | ovrSet;
      if (wrMask) irqMask <= hostBits;
      dbPulse <= dbAccept;
    end
  end

  assign copInDoorbell = dbPulse;
  assign copOutReady   = outReady;
  assign hostIrq       = |(irqStat & ~irqMask);

  always_comb begin
    strb.inPayWe  = hostWe && (hostAddr[5:4] == WIN_IN) && inReady;
    strb.outPayWe = copOutWe && outReady;
    strb.hostIdx  = hostAddr[IDX_W-1:0];
    case (hostAddr[5:4])
      WIN_IN:  strb.rdSel = RD_IN;
      WIN_OUT: strb.rdSel = RD_OUT;
      default: strb.rdSel = RD_REG;
    endcase

    regRdata = '0;
    case (hostAddr)
      REG_INSTAT:  regRdata[0]   = inReady;
      REG_IRQSTAT: regRdata[1:0] = irqStat;
      REG_IRQMASK: regRdata[1:0] = irqMask;
      REG_OUTACK:  regRdata[0]   = outReady;
      REG_OVERRUN: regRdata[1:0] = ovr;
      default:     regRdata      = '0;
    endcase
  end

  // R3
  db_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbPulse |-> (!inReady && $past(inReady)));

  // R4
  in_ready_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> irqStat[1]);

  // R5
  in_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovr[0]) |-> !$past(inReady));

  // R6
  out_post_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReady) |-> irqStat[0]);

  // R7
  out_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReady) |-> $past(hostWe && hostAddr == REG_OUTACK));
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
(
  input  logic              clk,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic [IDX_W-1:0]  copInRdAddr,
  input  logic [IDX_W-1:0]  copOutWAddr,
  input  logic [DATA_W-1:0] copOutWData,
  output logic [DATA_W-1:0] copInRdData,
  output logic [DATA_W-1:0] hostRdata
);
  logic [DATA_W-1:0] inMem  [PAY_WORDS];
  logic [DATA_W-1:0] outMem [PAY_WORDS];

  always_ff @(posedge clk) begin
    if (strb.inPayWe)  inMem[strb.hostIdx] <= hostWdata;
    if (strb.outPayWe) outMem[copOutWAddr] <= copOutWData;
  end

  assign copInRdData = inMem[copInRdAddr];

  always_comb begin
    case (strb.rdSel)
      RD_IN:   hostRdata = inMem[strb.hostIdx];
      RD_OUT:  hostRdata = outMem[strb.hostIdx];
      default: hostRdata = regRdata;
    endcase
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  output logic              copInDoorbell,
  input  logic              copInConsume,
  input  logic [IDX_W-1:0]  copInRdAddr,
  output logic [DATA_W-1:0] copInRdData,
  input  logic              copOutWe,
  input  logic [IDX_W-1:0]  copOutWAddr,
  input  logic [DATA_W-1:0] copOutWData,
  input  logic              copOutPost,
  output logic              copOutReady
);
  ctrlStrb_t         strb;
  logic [DATA_W-1:0] regRdata;

  mbx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostBits(hostWdata[1:0]), .copInConsume(copInConsume),
    .copOutWe(copOutWe), .copOutPost(copOutPost),
    .copInDoorbell(copInDoorbell), .copOutReady(copOutReady),
    .hostIrq(hostIrq), .regRdata(regRdata), .strb(strb)
  );

  mbx_datapath uDp (
    .clk(clk), .strb(strb), .hostWdata(hostWdata), .regRdata(regRdata),
    .copInRdAddr(copInRdAddr), .copOutWAddr(copOutWAddr),
    .copOutWData(copOutWData), .copInRdData(copInRdData),
    .hostRdata(hostRdata)
  );
endmodule

// File: tb/sim_mbx_doorbell.sv
`timescale 1ns/100ps
module sim_mbx_doorbell;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic        hostWe = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq, copInDoorbell, copOutReady;
  logic        copInConsume = 1'b0;
  logic [3:0]  copInRdAddr = '0;
  logic [31:0] copInRdData;
  logic        copOutWe = 1'b0;
  logic [3:0]  copOutWAddr = '0;
  logic [31:0] copOutWData = '0;
  logic        copOutPost = 1'b0;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_doorbell u0 (.*);

  // {index, data}
  localparam logic [35:0] VEC [8] = '{
    {4'd0,  32'hDEAD_BEEF}, {4'd1,  32'h0000_0001}, {4'd5,  32'hA5A5_5A5A},
    {4'd7,  32'hFFFF_FFFF}, {4'd8,  32'h1234_5678}, {4'd11, 32'h0F0F_F0F0},
    {4'd14, 32'h8000_0000}, {4'd15, 32'hCAFE_0015}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic hrd(logic [5:0] a, output logic [31:0] d);
    hostAddr = a; #1; d = hostRdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic coWr(logic [3:0] i, logic [31:0] d);
    @(negedge clk); copOutWAddr = i; copOutWData = d; copOutWe = 1'b1;
    @(negedge clk); copOutWe = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    hrd(6'h01, r); chk("R1 inReady", r, 1);
    hrd(6'h02, r); chk("R1 status", r, 0);
    hrd(6'h03, r); chk("R1 mask", r, 3);
    hrd(6'h04, r); chk("R1 outReady reg", r, 1);
    hrd(6'h05, r); chk("R1 overrun", r, 0);
    chk("R1 irq", hostIrq, 0);
    chk("R1 copOutReady", copOutReady, 1);
    chk("R1 doorbell", copInDoorbell, 0);

    // R2 payload table
    foreach (VEC[k]) hwr({2'b01, VEC[k][35:32]}, VEC[k][31:0]);
    foreach (VEC[k]) begin
      hrd({2'b01, VEC[k][35:32]}, r); chk("R2 host readback", r, VEC[k][31:0]);
      copInRdAddr = VEC[k][35:32]; #1;
      chk("R2 cop readback", copInRdData, VEC[k][31:0]);
    end

    // R3 doorbell accepted
    hwr(6'h00, 32'h0);
    chk("R3 pulse", copInDoorbell, 1);
    hrd(6'h01, r); chk("R3 inReady low", r, 0);
    @(negedge clk); chk("R3 pulse one cycle", copInDoorbell, 0);

    // R5 busy: payload write and doorbell ignored
    hwr(6'h10, 32'h5555_AAAA);
    hrd(6'h10, r); chk("R5 payload kept", r, 32'hDEAD_BEEF);
    hwr(6'h00, 32'h0);
    chk("R5 no pulse", copInDoorbell, 0);
    hrd(6'h05, r); chk("R5 overrun in", r, 1);
    // R11 sticky, then W1C
    @(negedge clk); hrd(6'h05, r); chk("R11 sticky", r, 1);
    hwr(6'h05, 32'h1); hrd(6'h05, r); chk("R11 cleared", r, 0);

    // R4 consume
    pulse(copInConsume);
    hrd(6'h01, r); chk("R4 inReady set", r, 1);
    hrd(6'h02, r); chk("R4 status bit1", r, 2);
    hwr(6'h02, 32'h2); hrd(6'h02, r); chk("R9 w1c", r, 0);
    pulse(copInConsume);
    hrd(6'h02, r); chk("R4 consume when ready no event", r, 0);
    hrd(6'h01, r); chk("R4 still ready", r, 1);

    // R10 mask gating
    hwr(6'h03, 32'h0); chk("R10 no status no irq", hostIrq, 0);
    hwr(6'h03, 32'h3);
    hwr(6'h00, 32'h0); pulse(copInConsume);
    chk("R10 masked", hostIrq, 0);
    hwr(6'h03, 32'h1); chk("R10 bit1 unmasked", hostIrq, 1);
    hwr(6'h03, 32'h2); chk("R10 bit0 unmasked only", hostIrq, 0);

    // R9 set wins over clear
    hwr(6'h00, 32'h0);
    @(negedge clk); hostAddr = 6'h02; hostWdata = 32'h2; hostWe = 1'b1; copInConsume = 1'b1;
    @(negedge clk); hostWe = 1'b0; copInConsume = 1'b0;
    hrd(6'h02, r); chk("R9 set wins", r, 2);
    hwr(6'h02, 32'h2); hrd(6'h02, r); chk("R9 cleared", r, 0);

    // R6 output post
    coWr(4'd3, 32'h0BAD_F00D);
    pulse(copOutPost);
    chk("R6 outReady low", copOutReady, 0);
    hrd(6'h02, r); chk("R6 status bit0", r, 1);
    hrd(6'h23, r); chk("R6 out payload", r, 32'h0BAD_F00D);
    chk("R10 out event irq", hostIrq, 1);

    // R7 busy output
    coWr(4'd3, 32'h1111_2222);
    hrd(6'h23, r); chk("R7 payload kept", r, 32'h0BAD_F00D);
    hwr(6'h02, 32'h1);
    pulse(copOutPost);
    hrd(6'h05, r); chk("R7 overrun out", r, 2);
    hrd(6'h02, r); chk("R7 no event", r, 0);
    hwr(6'h04, 32'h0);
    chk("R7 ack sets ready", copOutReady, 1);
    hwr(6'h05, 32'h3);

    // R8 same-edge ack and post
    pulse(copOutPost);
    hwr(6'h02, 32'h1);
    @(negedge clk); hostAddr = 6'h04; hostWe = 1'b1; copOutPost = 1'b1;
    @(negedge clk); hostWe = 1'b0; copOutPost = 1'b0;
    chk("R8 outReady low", copOutReady, 0);
    hrd(6'h02, r); chk("R8 status bit0", r, 1);
    hrd(6'h05, r); chk("R8 no overrun", r, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule